// File: doc/BRIEF.md
# CAVLC Coefficient Statistics Extractor

This block takes one block of quantized transform coefficients, loaded in parallel with a start pulse, and walks it in the zigzag scan order of its shape, one coefficient per clock. While it walks, it collects the statistics that a context-adaptive variable-length entropy coder needs:
- how many coefficients are nonzero;
- how many plus/minus one values close the nonzero sequence, and their signs;
- how many zeros sit ahead of the last nonzero coefficient;
- the nonzero levels, each with the length of the zero run that precedes it.

When the walk ends, the block raises a one-cycle done flag. The statistics are then held on registered outputs. In the same cycle the block starts to present a level/run list, one entry per cycle, beginning with the highest-frequency coefficient.

A downstream codeword stage reads the statistics to select and emit its token, trailing-sign, total-zero and run codes. It consumes the list entries as they appear. Three shapes are handled: a 4x4 block of 16 coefficients, a 2x4 block of 8 coefficients and a 2x2 block of 4 coefficients. Codeword tables, bit packing and neighbour context prediction belong to other blocks.

Top module: `cavlc_stat_extract`

## Requirements
- R1: For shape code 0, lane `i` of `coef_i` (bits `i*16+15 : i*16`) holds row `i/4`, column `i%4`. The lanes are visited in the order 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15.
- R2: `total_coef_o` equals the number of nonzero coefficients among the visited lanes. It is valid from the done cycle and holds until the next accepted start.
- R3: `trail_ones_o` counts the coefficients of magnitude 1, starting at the last nonzero coefficient in scan order and going backwards. The count stops at the first nonzero coefficient whose magnitude is not 1, and it never exceeds 3.
- R4: Bit `k` of `trail_sign_o` is the sign of the k-th trailing one counted from the last nonzero coefficient, with bit 0 being that last coefficient. A value of 1 means negative. Bits at or above `trail_ones_o` are 0.
- R5: `total_zeros_o` equals the number of zero coefficients that come before the last nonzero coefficient in scan order. It is 0 when the block has no nonzero coefficient.
- R6: The list is presented in reverse scan order, one entry per cycle while `list_valid_o` is high. Each entry gives the level as a signed value and the zero run that precedes that coefficient. The final entry is the lowest-frequency nonzero coefficient: it carries `list_last_o`=1 and a run field of 0.
- R7: Shape code 1 visits lanes 0,2,1,5,3,6,4,7. Shape code 2 visits lanes 0,1,2,3. Shape code 3 behaves as shape code 0. Lanes outside the visited set have no effect on any output.
- R8: `done_o` is a one-cycle pulse that is high exactly N clock cycles after the edge that accepts start, where N is 16, 8 or 4 for the shape. The first list entry is shown in the same cycle, and the remaining entries follow in consecutive cycles.
- R9: A block with no nonzero coefficient gives a count of 0, 0 trailing ones and 0 total zeros. It shows no list entry, and `busy_o` is already low in the cycle `done_o` is high.
- R10: `busy_o` is high from the edge that accepts start until the last list entry has been shown. A start pulse while busy is ignored, together with the shape and coefficient inputs of that cycle.
- R11: After reset, `busy_o`, `done_o`, `list_valid_o` and all statistics outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Accept a new block when idle |
| shape_i | input | 2 | Block shape: 0 4x4, 1 2x4, 2 2x2, 3 as 4x4 |
| coef_i | input | 256 | Sixteen signed 16-bit coefficient lanes, lane i at bits i*16 upward |
| busy_o | output | 1 | Block is scanning or presenting its list |
| done_o | output | 1 | One-cycle pulse when the scan has finished |
| total_coef_o | output | 5 | Number of nonzero coefficients |
| trail_ones_o | output | 2 | Trailing plus/minus one count, at most 3 |
| trail_sign_o | output | 3 | Trailing one signs, bit 0 for the last nonzero |
| total_zeros_o | output | 4 | Zeros ahead of the last nonzero coefficient |
| list_valid_o | output | 1 | A list entry is presented this cycle |
| list_level_o | output | 16 | Signed level of the current entry |
| list_run_o | output | 4 | Zeros preceding the current entry's coefficient |
| list_last_o | output | 1 | Current entry is the final one |

## Verification
The hardest case to reach is a trailing-ones tail that is cut short. This needs a coefficient of magnitude 2 or more placed directly before a few final plus/minus ones, in scan order rather than raster order. Blocks dense enough to saturate the count at 3 are also needed. The bench places these values by working out raster lanes from the scan order, and it adds random blocks with small levels (−2 to 2, many zeros) across all shapes. A second start, carrying a different shape and different data, is pulsed while the first block is still busy; the outputs must still match the first block, cycle by cycle.

// File: rtl/cavlc_pkg.sv
// Package: shared constants, shape codes, controller states and the
// scan length of each shape. Assumes a block never exceeds 16 coefficients.
package cavlc_pkg;

    localparam int MAX_N = 16;
    localparam int IDX_W = $clog2(MAX_N);
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam int T1_MAX = 3;

    typedef enum logic [1:0] {
        SHAPE_4X4 = 2'd0,
        SHAPE_2X4 = 2'd1,
        SHAPE_2X2 = 2'd2,
        SHAPE_ALT = 2'd3
    } shape_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } state_e;

    // Number of coefficients visited for a shape code.
    function automatic logic [CNT_W-1:0] scan_len(input logic [1:0] shape);
        case (shape)
            SHAPE_2X4: scan_len = CNT_W'(8);
            SHAPE_2X2: scan_len = CNT_W'(4);
            default:   scan_len = CNT_W'(MAX_N);
        endcase
    endfunction

endpackage

// File: rtl/cavlc_scan_order.sv
// cavlc_scan_order: maps a scan index to the raster lane of the coefficient,
// per shape. Purely combinational. Assumes idx is below the shape's length.
module cavlc_scan_order
    import cavlc_pkg::*;
(
    input  logic [1:0]       shape,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] lane
);

    logic [IDX_W-1:0] zz_lane;
    logic [IDX_W-1:0] r24_lane;

    // 4x4 zigzag: index to lane.
    always_comb begin
        case (idx)
            4'd0:  zz_lane = 4'd0;
            4'd1:  zz_lane = 4'd1;
            4'd2:  zz_lane = 4'd4;
            4'd3:  zz_lane = 4'd8;
            4'd4:  zz_lane = 4'd5;
            4'd5:  zz_lane = 4'd2;
            4'd6:  zz_lane = 4'd3;
            4'd7:  zz_lane = 4'd6;
            4'd8:  zz_lane = 4'd9;
            4'd9:  zz_lane = 4'd12;
            4'd10: zz_lane = 4'd13;
            4'd11: zz_lane = 4'd10;
            4'd12: zz_lane = 4'd7;
            4'd13: zz_lane = 4'd11;
            4'd14: zz_lane = 4'd14;
            default: zz_lane = 4'd15;
        endcase
    end

    // 2x4 order: fixed eight-entry table.
    always_comb begin
        case (idx[2:0])
            3'd0: r24_lane = 4'd0;
            3'd1: r24_lane = 4'd2;
            3'd2: r24_lane = 4'd1;
            3'd3: r24_lane = 4'd5;
            3'd4: r24_lane = 4'd3;
            3'd5: r24_lane = 4'd6;
            3'd6: r24_lane = 4'd4;
            default: r24_lane = 4'd7;
        endcase
    end

    // Shape select: 2x2 is raster order, unused code falls back to 4x4.
    always_comb begin
        case (shape)
            SHAPE_2X4: lane = r24_lane;
            SHAPE_2X2: lane = idx;
            default:   lane = zz_lane;
        endcase
    end

endmodule

// File: rtl/cavlc_scan_ctrl.sv
// cavlc_scan_ctrl: sequences idle, scan and list emission. It accepts start
// only when idle, steps one scan index per clock, pulses done after the final
// index and then counts the list pointer down to zero. Assumes cnt_next is
// the nonzero count including the coefficient scanned in the current cycle.
module cavlc_scan_ctrl
    import cavlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       shape_i,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             load,
    output logic             step,
    output logic [1:0]       shape_q,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rd_ptr,
    output logic             emitting,
    output logic             busy,
    output logic             done
);

    state_e           state;
    logic             last_scan;
    logic [CNT_W-1:0] len;

    // Derived control strobes.
    always_comb begin
        len       = scan_len(shape_q);
        load      = (state == ST_IDLE) && start_i;
        step      = (state == ST_SCAN);
        last_scan = step && ({1'b0, idx} == (len - 1'b1));
        emitting  = (state == ST_EMIT);
        busy      = (state != ST_IDLE);
    end

    // State, index, list pointer and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            rd_ptr  <= '0;
            shape_q <= SHAPE_4X4;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state   <= ST_SCAN;
                        idx     <= '0;
                        shape_q <= shape_i;
                    end
                end
                ST_SCAN: begin
                    if (last_scan) begin
                        done <= 1'b1;
                        idx  <= '0;
                        if (cnt_next != '0) begin
                            state  <= ST_EMIT;
                            rd_ptr <= IDX_W'(cnt_next - 1'b1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (rd_ptr == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        rd_ptr <= rd_ptr - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cavlc_coef_accum.sv
// cavlc_coef_accum: consumes one coefficient per step in scan order. It counts
// nonzero values, tracks the tail of magnitude-one values and their signs,
// remembers the last nonzero position, and stores each level with the zero
// run before it. Assumes clear comes before the first step of a block.
module cavlc_coef_accum
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [COEF_W-1:0] coef,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  rd_ptr,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_next,
    output logic [1:0]        t1_q,
    output logic [T1_MAX-1:0] sign_q,
    output logic [IDX_W-1:0]  total_zeros,
    output logic [COEF_W-1:0] rd_level,
    output logic [IDX_W-1:0]  rd_run
);

    logic [IDX_W-1:0]  zrun_q;
    logic [IDX_W-1:0]  last_pos_q;
    logic [COEF_W-1:0] level_mem [MAX_N];
    logic [IDX_W-1:0]  run_mem   [MAX_N];
    logic              nz;
    logic              mag1;

    // Classify the coefficient of this step.
    always_comb begin
        nz       = (coef != '0);
        mag1     = (coef == COEF_W'(1)) || (coef == '1);
        cnt_next = cnt_q + CNT_W'(step && nz);
    end

    // Counters, trailing-one tracker and last position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q      <= '0;
            zrun_q     <= '0;
            t1_q       <= '0;
            sign_q     <= '0;
            last_pos_q <= '0;
        end else if (step) begin
            if (nz) begin
                cnt_q      <= cnt_q + 1'b1;
                zrun_q     <= '0;
                last_pos_q <= idx;
                if (mag1) begin
                    if (t1_q != 2'(T1_MAX)) begin
                        t1_q <= t1_q + 1'b1;
                    end
                    sign_q <= {sign_q[T1_MAX-2:0], coef[COEF_W-1]};
                end else begin
                    t1_q   <= '0;
                    sign_q <= '0;
                end
            end else begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // Level and preceding-run store; contents only read after being written.
    always_ff @(posedge clk) begin
        if (step && nz) begin
            level_mem[cnt_q[IDX_W-1:0]] <= coef;
            run_mem[cnt_q[IDX_W-1:0]]   <= zrun_q;
        end
    end

    // Total zeros and list read port.
    always_comb begin
        total_zeros = (cnt_q == '0) ? '0
                    : IDX_W'(CNT_W'(last_pos_q) + 1'b1 - cnt_q);
        rd_level    = level_mem[rd_ptr];
        rd_run      = (rd_ptr == '0) ? '0 : run_mem[rd_ptr];
    end

endmodule

// File: rtl/cavlc_stat_extract.sv
// cavlc_stat_extract: top. It captures a coefficient block on an accepted
// start, scans it in shape order and exposes the entropy-coder statistics
// plus a reverse-order level/run list. Assumes statistics are only consumed
// from the done cycle on; they move while the scan runs.
module cavlc_stat_extract
    import cavlc_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [1:0]              shape_i,
    input  logic [MAX_N*COEF_W-1:0] coef_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [CNT_W-1:0]        total_coef_o,
    output logic [1:0]              trail_ones_o,
    output logic [T1_MAX-1:0]       trail_sign_o,
    output logic [IDX_W-1:0]        total_zeros_o,
    output logic                    list_valid_o,
    output logic [COEF_W-1:0]       list_level_o,
    output logic [IDX_W-1:0]        list_run_o,
    output logic                    list_last_o
);

    logic              load;
    logic              step;
    logic [1:0]        shape_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  lane;
    logic [IDX_W-1:0]  rd_ptr;
    logic              emitting;
    logic [CNT_W-1:0]  cnt_next;
    logic [COEF_W-1:0] coef_q [MAX_N];
    logic [COEF_W-1:0] coef_sel;

    // Capture register per lane, loaded only on an accepted start.
    for (genvar g = 0; g < MAX_N; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef_q[g] <= '0;
            end else if (load) begin
                coef_q[g] <= coef_i[g*COEF_W +: COEF_W];
            end
        end
    end

    cavlc_scan_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .shape_i  (shape_i),
        .cnt_next (cnt_next),
        .load     (load),
        .step     (step),
        .shape_q  (shape_q),
        .idx      (idx),
        .rd_ptr   (rd_ptr),
        .emitting (emitting),
        .busy     (busy_o),
        .done     (done_o)
    );

    cavlc_scan_order u_order (
        .shape (shape_q),
        .idx   (idx),
        .lane  (lane)
    );

    // Select the coefficient at the current scan position.
    always_comb coef_sel = coef_q[lane];

    cavlc_coef_accum #(.COEF_W(COEF_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (load),
        .step        (step),
        .coef        (coef_sel),
        .idx         (idx),
        .rd_ptr      (rd_ptr),
        .cnt_q       (total_coef_o),
        .cnt_next    (cnt_next),
        .t1_q        (trail_ones_o),
        .sign_q      (trail_sign_o),
        .total_zeros (total_zeros_o),
        .rd_level    (list_level_o),
        .rd_run      (list_run_o)
    );

    // List handshake flags.
    always_comb begin
        list_valid_o = emitting;
        list_last_o  = emitting && (rd_ptr == '0);
    end

endmodule

// File: rtl/cavlc_stat_extract_chk.sv
// cavlc_stat_extract_chk: temporal checks on the top's ports, bound to it.
module cavlc_stat_extract_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [4:0] total_coef_o,
    input logic [1:0] trail_ones_o,
    input logic [2:0] trail_sign_o,
    input logic [3:0] total_zeros_o,
    input logic       list_valid_o,
    input logic       list_last_o
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6
    list_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        list_valid_o |-> busy_o);

    // R6
    last_ends_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (list_valid_o && list_last_o) |=> !list_valid_o);

    // R3
    t1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({3'd0, trail_ones_o} <= total_coef_o));

    // R4
    sign_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((trail_sign_o >> trail_ones_o) == 3'd0));

    // R5
    zeros_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (({2'd0, total_zeros_o} + {1'b0, total_coef_o}) <= 6'd16));

    // R9
    empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && total_coef_o == 5'd0) |-> (!busy_o && !list_valid_o));

endmodule

bind cavlc_stat_extract cavlc_stat_extract_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .total_coef_o  (total_coef_o),
    .trail_ones_o  (trail_ones_o),
    .trail_sign_o  (trail_sign_o),
    .total_zeros_o (total_zeros_o),
    .list_valid_o  (list_valid_o),
    .list_last_o   (list_last_o)
);

// File: tb/cavlc_stat_extract_bench.sv
// Bench: a behavioural model computes the expected statistics and list, and
// the outputs are compared every cycle of each block.
module cavlc_stat_extract_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   shape_i = 2'd0;
    logic [255:0] coef_i = '0;
    logic         busy_o, done_o, list_valid_o, list_last_o;
    logic [4:0]   total_coef_o;
    logic [1:0]   trail_ones_o;
    logic [2:0]   trail_sign_o;
    logic [3:0]   total_zeros_o;
    logic [15:0]  list_level_o;
    logic [3:0]   list_run_o;

    int checks = 0;
    int failures = 0;
    int blk [16];

    always #4 clk = ~clk;

    cavlc_stat_extract u_cavlc_stat_extract (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shape_i(shape_i),
        .coef_i(coef_i), .busy_o(busy_o), .done_o(done_o),
        .total_coef_o(total_coef_o), .trail_ones_o(trail_ones_o),
        .trail_sign_o(trail_sign_o), .total_zeros_o(total_zeros_o),
        .list_valid_o(list_valid_o), .list_level_o(list_level_o),
        .list_run_o(list_run_o), .list_last_o(list_last_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lane_of(input int shp, input int k);
        int zz [16] = '{0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15};
        int o24 [8] = '{0,2,1,5,3,6,4,7};
        if (shp == 1) return o24[k];
        if (shp == 2) return k;
        return zz[k];
    endfunction

    // Run one block through the design; poke sends a start while busy.
    task automatic run_block(input int shp, input bit poke);
        int n, tc, tz, t1, sg, zr, lastpos;
        int lv [$];
        int rb [$];
        n = (shp == 1) ? 8 : (shp == 2) ? 4 : 16;
        tc = 0; zr = 0; lastpos = -1;
        for (int k = 0; k < n; k++) begin
            int v;
            v = blk[lane_of(shp, k)];
            if (v != 0) begin
                lv.push_back(v); rb.push_back(zr); tc++; zr = 0; lastpos = k;
            end else zr++;
        end
        tz = (tc > 0) ? lastpos + 1 - tc : 0;
        t1 = 0; sg = 0;
        for (int j = tc - 1; j >= 0; j--) begin
            if (t1 < 3 && (lv[j] == 1 || lv[j] == -1)) begin
                if (lv[j] < 0) sg |= (1 << t1);
                t1++;
            end else break;
        end
        @(negedge clk);
        start_i = 1'b1; shape_i = 2'(shp);
        for (int i = 0; i < 16; i++) coef_i[i*16 +: 16] = 16'(blk[i]);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= n + tc; k++) begin
            chk("R10", "busy", int'(busy_o), int'(k < n + tc));
            chk("R8", "done", int'(done_o), int'(k == n));
            chk("R6", "list_valid", int'(list_valid_o), int'(k >= n && k < n + tc));
            if (k == n) begin
                chk("R2", "total_coef", int'(total_coef_o), tc);
                chk("R3", "trail_ones", int'(trail_ones_o), t1);
                chk("R4", "trail_sign", int'(trail_sign_o), sg);
                chk("R5", "total_zeros", int'(total_zeros_o), tz);
                if (tc == 0) chk("R9", "empty busy", int'(busy_o), 0);
            end
            if (k >= n && k < n + tc) begin
                int j;
                j = tc - 1 - (k - n);
                chk("R6", "level", int'($signed(list_level_o)), lv[j]);
                chk("R6", "run", int'(list_run_o), (j > 0) ? rb[j] : 0);
                chk("R6", "last", int'(list_last_o), int'(j == 0));
            end
            if (poke && k == 1) begin
                start_i = 1'b1; shape_i = 2'd2; coef_i = {16{16'h0001}};
            end
            if (poke && k == 2) start_i = 1'b0;
            @(negedge clk);
        end
        chk("R2", "held total_coef", int'(total_coef_o), tc);
        chk("R10", "idle after block", int'(busy_o), 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "busy", int'(busy_o), 0);
        chk("R11", "done", int'(done_o), 0);
        chk("R11", "list_valid", int'(list_valid_o), 0);
        chk("R11", "total_coef", int'(total_coef_o), 0);
        chk("R11", "total_zeros", int'(total_zeros_o), 0);

        // R9: all-zero 4x4 block
        foreach (blk[i]) blk[i] = 0;
        run_block(0, 0);

        // R1 R3: mixed 4x4 with three trailing ones
        blk = '{0,3,-1,0, 0,-1,1,0, 1,0,0,0, 0,0,0,0};
        run_block(0, 0);

        // R3 R4: dense block, tail saturates at 3
        foreach (blk[i]) blk[i] = (i % 3 == 0) ? -1 : 1;
        blk[0] = 5;
        run_block(0, 0);

        // R3: scan tail 1, -2, -1 cut by magnitude 2 (zigzag idx 13,14,15)
        foreach (blk[i]) blk[i] = 0;
        blk[0] = 7; blk[11] = 1; blk[14] = -2; blk[15] = -1;
        run_block(0, 0);

        // R5 R6: only the last zigzag position, most negative level
        foreach (blk[i]) blk[i] = 0;
        blk[15] = -32768;
        run_block(0, 0);

        // R7 R10: 2x4 block with an ignored start while busy
        foreach (blk[i]) blk[i] = 9;
        blk[0] = 0; blk[1] = -1; blk[2] = 4; blk[3] = 0;
        blk[4] = 0; blk[5] = 0; blk[6] = 1; blk[7] = 0;
        run_block(1, 1);

        // R7: 2x2 block, upper lanes loaded with data that must be ignored
        foreach (blk[i]) blk[i] = -3;
        blk[0] = 0; blk[1] = 2; blk[2] = 0; blk[3] = -1;
        run_block(2, 1);

        // R7: shape code 3 behaves as 4x4
        blk = '{0,3,-1,0, 0,-1,1,0, 1,0,0,0, 0,0,0,0};
        run_block(3, 0);

        // R2 R6: random sparse blocks on every shape
        for (int r = 0; r < 24; r++) begin
            foreach (blk[i]) blk[i] = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 4)) - 2 : 0;
            run_block(r % 4, r % 5 == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule